// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Controller

This block is an SPI master that runs an external eight-input, 16-bit successive-approximation converter. Once reset is released it sends the converter's software-reset command a single time. After that it accepts two kinds of work. The first is a scan trigger: it reads every channel enabled in a mask, in ascending channel order. The second is a request to program one channel's input-range register.

Each channel in a scan costs two chip-select windows. The first window carries a command that selects the channel. The second carries a no-op command, and the converter returns the conversion result during its low half. Results leave on a valid/ready stream tagged with the channel number. They are packed with no gaps for disabled channels, and the final result of a scan is flagged.

A programmable divider derives the serial clock from the system clock. The link runs in SPI mode 1.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is asserted, `spi_csn_o` is 1, `spi_sclk_o` is 0, and `res_valid_o`, `rng_err_o` and `overrun_o` are 0. In the first cycle after reset is released, `busy_o` is 1.
- R2: The first frame after reset is a single 32-bit frame. Its bits 31:24 hold the reset code 0x85 and its bits 23:0 are zero. `busy_o` stays high until that frame has ended.
- R3: Serial timing is SPI mode 1. SCLK idles low whenever chip select is high. MOSI changes only on rising SCLK edges and holds while SCLK is high. MISO is captured on falling edges. Bits are sent MSB first. Every SCLK half period lasts `clk_div_i`+1 system clocks.
- R4: Every frame has its own chip-select window. Between windows, `spi_csn_o` stays high for at least `clk_div_i`+1 system clocks.
- R5: On a scan, each enabled channel n, taken in ascending order, gets a 32-bit select frame followed by a 32-bit no-op frame. The select frame carries code 0xC0 OR 4·n in bits 31:24 and zeros in bits 23:0. The no-op frame is all zero.
- R6: Each result is the low 16 bits of the MISO word captured during the no-op frame. `res_chan_o` gives n. `res_last_o` is 1 only on the final result of the scan.
- R7: A scan yields exactly as many results and twice as many frames as there are set bits in the mask. An all-zero mask produces no frame, no result and no busy period.
- R8: While `res_valid_o` is 1 and `res_ready_i` is 0, the result and its tags hold steady and no new frame begins.
- R9: A range request with code 0, 1, 2, 5 or 6 sends one 24-bit frame. The frame carries address 0x05+channel in bits 23:17, a 1 in bit 16, the code in bits 15:8 and zeros in bits 7:0.
- R10: A range request with any other code sends no frame and instead raises `rng_err_o` for exactly one cycle.
- R11: A trigger that arrives while `busy_o` is 1 sets `overrun_o`, which stays set until reset. The trigger is otherwise dropped and causes no frame or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div_i | input | DIV_W | SCLK half period in system clocks, minus one |
| scan_trig_i | input | 1 | Start a scan (one-cycle pulse) |
| chan_mask_i | input | NCH | Channels to read, sampled with the trigger |
| rng_req_i | input | 1 | Range-write request (one-cycle pulse, taken while idle) |
| rng_chan_i | input | CH_W | Channel whose range register is written |
| rng_code_i | input | 8 | Range code to write |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | DATA_W | Conversion result |
| res_chan_o | output | CH_W | Channel of the result |
| res_last_o | output | 1 | Final result of the scan |
| busy_o | output | 1 | Start-up, scan or range write in progress |
| rng_err_o | output | 1 | One-cycle pulse for a rejected range code |
| overrun_o | output | 1 | Sticky flag for a trigger dropped while busy |
| spi_sclk_o | output | 1 | Serial clock |
| spi_csn_o | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the converter |
| spi_miso_i | input | 1 | Serial data from the converter |

## Verification
Several properties are checked on every cycle:
- SCLK stays low whenever chip select is high, and MOSI does not move while SCLK is high.
- A held result stays frozen and no frame starts during back-pressure.
- The overrun flag never clears once set.
- Every error pulse can be traced to a request with a disallowed code.

Other behaviour only the bench scenarios can show:
- Frame contents and bit order, observed through a converter model.
- The measured half-period and chip-select gap lengths.
- Ascending and packed channel order over many masks.
- Pairing of each result with the converter's reply.
- Which of all 256 range codes are accepted.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   localparam int WORD_W   = 32;
   localparam int BITCNT_W = $clog2(WORD_W + 1);

   localparam logic [7:0] OP_NOP      = 8'h00;
   localparam logic [7:0] OP_RESET    = 8'h85;
   localparam logic [7:0] OP_SEL_BASE = 8'hC0;
   localparam logic [6:0] RNG_ADDR0   = 7'h05;

   localparam logic [BITCNT_W-1:0] LEN_CMD  = BITCNT_W'(32);
   localparam logic [BITCNT_W-1:0] LEN_PROG = BITCNT_W'(24);

   typedef enum logic [2:0] {
      SQ_BOOT, SQ_BOOT_W, SQ_IDLE, SQ_SEL_W, SQ_NOP_W, SQ_OUT, SQ_RNG_W
   } seq_state_t;

   typedef enum logic [1:0] {
      FE_IDLE, FE_SHIFT, FE_TAIL, FE_GAP
   } fe_state_t;

   // allowed input-range codes
   function automatic logic range_code_ok(input logic [7:0] c);
      return (c == 8'd0) || (c == 8'd1) || (c == 8'd2) || (c == 8'd5) || (c == 8'd6);
   endfunction

   // 32-bit channel select command, left aligned
   function automatic logic [WORD_W-1:0] sel_word(input logic [3:0] ch);
      return {OP_SEL_BASE | {2'b00, ch, 2'b00}, 24'h000000};
   endfunction

   // 24-bit program-register write, left aligned in the shift word
   function automatic logic [WORD_W-1:0] prog_word(input logic [3:0] ch, input logic [7:0] d);
      logic [6:0] a;
      a = RNG_ADDR0 + {3'b000, ch};
      return {a, 1'b1, d, 8'h00, 8'h00};
   endfunction

endpackage

// File: rtl/chan_pick.sv
module chan_pick #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   logic [N-1:0] grant;

   // isolate lowest set bit: lowest index wins
   assign grant = req_i & (~req_i + 1'b1);
   assign any_o = |req_i;

   generate
      for (genvar b = 0; b < IW; b++) begin : g_enc
         logic [N-1:0] sel_bits;
         always_comb begin
            sel_bits = '0;
            for (int i = 0; i < N; i++) begin
               sel_bits[i] = ((i >> b) & 1) != 0;
            end
         end
         assign idx_o[b] = |(grant & sel_bits);
      end
   endgenerate
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import adc_scan_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int RX_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    div_i,
   input  logic                start_i,
   input  logic [BITCNT_W-1:0] nbits_i,
   input  logic [WORD_W-1:0]   tx_i,
   input  logic                miso_i,
   output logic                sclk_o,
   output logic                csn_o,
   output logic                mosi_o,
   output logic [RX_W-1:0]     rx_o,
   output logic                done_o
);
   generate
      if (RX_W < 2 || RX_W > WORD_W) begin : g_bad_rx
         $error("spi_frame_engine: RX_W out of range");
      end
   endgenerate

   fe_state_t           st_q;
   logic [DIV_W-1:0]    cnt_q;
   logic                tick;
   logic [WORD_W-1:0]   sh_q;
   logic [RX_W-1:0]     rx_q;
   logic [BITCNT_W-1:0] bit_q, len_q;
   logic                sclk_q, csn_q, mosi_q, done_q;

   assign tick = (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FE_IDLE;
         cnt_q  <= '0;
         sh_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
         len_q  <= '0;
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
         mosi_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (st_q == FE_IDLE) cnt_q <= '0;
         else                 cnt_q <= tick ? '0 : cnt_q + 1'b1;
         case (st_q)
            FE_IDLE: begin
               if (start_i) begin
                  st_q  <= FE_SHIFT;
                  csn_q <= 1'b0;
                  sh_q  <= tx_i;
                  len_q <= nbits_i;
                  bit_q <= '0;
               end
            end
            FE_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     mosi_q <= sh_q[WORD_W-1];
                     sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                  end else begin
                     sclk_q <= 1'b0;
                     rx_q   <= {rx_q[RX_W-2:0], miso_i};
                     if (bit_q == len_q - 1'b1) st_q  <= FE_TAIL;
                     else                       bit_q <= bit_q + 1'b1;
                  end
               end
            end
            FE_TAIL: begin
               if (tick) begin
                  csn_q  <= 1'b1;
                  mosi_q <= 1'b0;
                  st_q   <= FE_GAP;
               end
            end
            default: begin
               if (tick) begin
                  done_q <= 1'b1;
                  st_q   <= FE_IDLE;
               end
            end
         endcase
      end
   end

   assign sclk_o = sclk_q;
   assign csn_o  = csn_q;
   assign mosi_o = mosi_q;
   assign rx_o   = rx_q;
   assign done_o = done_q;

   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csn_o |-> !sclk_o);

   // R3
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

   // R4
   gap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (csn_o && !sclk_o && $past(csn_o)));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
   import adc_scan_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int DATA_W = 16,
   parameter int CH_W   = $clog2(NCH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_i,
   input  logic [NCH-1:0]      mask_i,
   input  logic                rng_req_i,
   input  logic [CH_W-1:0]     rng_chan_i,
   input  logic [7:0]          rng_code_i,
   input  logic                fe_done_i,
   input  logic [DATA_W-1:0]   fe_rx_i,
   output logic                fe_start_o,
   output logic [BITCNT_W-1:0] fe_nbits_o,
   output logic [WORD_W-1:0]   fe_tx_o,
   output logic                res_valid_o,
   input  logic                res_ready_i,
   output logic [DATA_W-1:0]   res_data_o,
   output logic [CH_W-1:0]     res_chan_o,
   output logic                res_last_o,
   output logic                busy_o,
   output logic                rng_err_o,
   output logic                overrun_o
);
   seq_state_t          state_q;
   logic [NCH-1:0]      mask_q, pick_src, rest_mask;
   logic [CH_W-1:0]     cur_ch, pick_ch;
   logic                pick_any;
   logic                start_q, valid_q, last_q, err_q, ovr_q;
   logic [BITCNT_W-1:0] nbits_q;
   logic [WORD_W-1:0]   tx_q;
   logic [DATA_W-1:0]   data_q;
   logic [CH_W-1:0]     chan_q;

   assign pick_src = (state_q == SQ_IDLE) ? mask_i : mask_q;

   chan_pick #(.N(NCH), .IW(CH_W)) u_pick (
      .req_i (pick_src),
      .idx_o (pick_ch),
      .any_o (pick_any)
   );

   always_comb begin
      rest_mask          = mask_q;
      rest_mask[cur_ch]  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_BOOT;
         mask_q  <= '0;
         cur_ch  <= '0;
         start_q <= 1'b0;
         nbits_q <= LEN_CMD;
         tx_q    <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
         chan_q  <= '0;
         last_q  <= 1'b0;
         err_q   <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         err_q   <= 1'b0;
         if (trig_i && state_q != SQ_IDLE) ovr_q <= 1'b1;
         case (state_q)
            SQ_BOOT: begin
               start_q <= 1'b1;
               nbits_q <= LEN_CMD;
               tx_q    <= {OP_RESET, 24'h000000};
               state_q <= SQ_BOOT_W;
            end
            SQ_BOOT_W: if (fe_done_i) state_q <= SQ_IDLE;
            SQ_IDLE: begin
               if (trig_i) begin
                  if (pick_any) begin
                     mask_q  <= mask_i;
                     cur_ch  <= pick_ch;
                     start_q <= 1'b1;
                     nbits_q <= LEN_CMD;
                     tx_q    <= sel_word(4'(pick_ch));
                     state_q <= SQ_SEL_W;
                  end
               end else if (rng_req_i) begin
                  if (range_code_ok(rng_code_i)) begin
                     start_q <= 1'b1;
                     nbits_q <= LEN_PROG;
                     tx_q    <= prog_word(4'(rng_chan_i), rng_code_i);
                     state_q <= SQ_RNG_W;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            SQ_SEL_W: begin
               if (fe_done_i) begin
                  start_q <= 1'b1;
                  nbits_q <= LEN_CMD;
                  tx_q    <= {OP_NOP, 24'h000000};
                  state_q <= SQ_NOP_W;
               end
            end
            SQ_NOP_W: begin
               if (fe_done_i) begin
                  valid_q <= 1'b1;
                  data_q  <= fe_rx_i;
                  chan_q  <= cur_ch;
                  last_q  <= (rest_mask == '0);
                  mask_q  <= rest_mask;
                  state_q <= SQ_OUT;
               end
            end
            SQ_OUT: begin
               if (res_ready_i) begin
                  valid_q <= 1'b0;
                  if (pick_any) begin
                     cur_ch  <= pick_ch;
                     start_q <= 1'b1;
                     nbits_q <= LEN_CMD;
                     tx_q    <= sel_word(4'(pick_ch));
                     state_q <= SQ_SEL_W;
                  end else begin
                     state_q <= SQ_IDLE;
                  end
               end
            end
            default: if (fe_done_i) state_q <= SQ_IDLE;
         endcase
      end
   end

   assign fe_start_o  = start_q;
   assign fe_nbits_o  = nbits_q;
   assign fe_tx_o     = tx_q;
   assign res_valid_o = valid_q;
   assign res_data_o  = data_q;
   assign res_chan_o  = chan_q;
   assign res_last_o  = last_q;
   assign busy_o      = (state_q != SQ_IDLE);
   assign rng_err_o   = err_q;
   assign overrun_o   = ovr_q;

   // R8
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)
                                         && $stable(res_chan_o) && $stable(res_last_o)));

   // R8
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> !fe_start_o);

   // R11
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

   // R10
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rng_err_o |-> ($past(rng_req_i) && !range_code_ok($past(rng_code_i))));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter  int NCH    = 8,
   parameter  int DATA_W = 16,
   parameter  int DIV_W  = 8,
   localparam int CH_W   = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  clk_div_i,
   input  logic              scan_trig_i,
   input  logic [NCH-1:0]    chan_mask_i,
   input  logic              rng_req_i,
   input  logic [CH_W-1:0]   rng_chan_i,
   input  logic [7:0]        rng_code_i,
   output logic              res_valid_o,
   input  logic              res_ready_i,
   output logic [DATA_W-1:0] res_data_o,
   output logic [CH_W-1:0]   res_chan_o,
   output logic              res_last_o,
   output logic              busy_o,
   output logic              rng_err_o,
   output logic              overrun_o,
   output logic              spi_sclk_o,
   output logic              spi_csn_o,
   output logic              spi_mosi_o,
   input  logic              spi_miso_i
);
   generate
      if (NCH < 2 || NCH > 16) begin : g_bad_nch
         $error("adc_scan_ctrl: NCH must be 2..16");
      end
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_dw
         $error("adc_scan_ctrl: DATA_W must be 2..16");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("adc_scan_ctrl: DIV_W must be positive");
      end
   endgenerate

   logic                fe_start, fe_done;
   logic [BITCNT_W-1:0] fe_nbits;
   logic [WORD_W-1:0]   fe_tx;
   logic [DATA_W-1:0]   fe_rx;

   scan_sequencer #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (scan_trig_i),
      .mask_i      (chan_mask_i),
      .rng_req_i   (rng_req_i),
      .rng_chan_i  (rng_chan_i),
      .rng_code_i  (rng_code_i),
      .fe_done_i   (fe_done),
      .fe_rx_i     (fe_rx),
      .fe_start_o  (fe_start),
      .fe_nbits_o  (fe_nbits),
      .fe_tx_o     (fe_tx),
      .res_valid_o (res_valid_o),
      .res_ready_i (res_ready_i),
      .res_data_o  (res_data_o),
      .res_chan_o  (res_chan_o),
      .res_last_o  (res_last_o),
      .busy_o      (busy_o),
      .rng_err_o   (rng_err_o),
      .overrun_o   (overrun_o)
   );

   spi_frame_engine #(.DIV_W(DIV_W), .RX_W(DATA_W)) u_fe (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_i   (clk_div_i),
      .start_i (fe_start),
      .nbits_i (fe_nbits),
      .tx_i    (fe_tx),
      .miso_i  (spi_miso_i),
      .sclk_o  (spi_sclk_o),
      .csn_o   (spi_csn_o),
      .mosi_o  (spi_mosi_o),
      .rx_o    (fe_rx),
      .done_o  (fe_done)
   );
endmodule

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [7:0]  clk_div = 8'd0;
   logic        scan_trig = 1'b0;
   logic [7:0]  chan_mask = 8'h00;
   logic        rng_req = 1'b0;
   logic [2:0]  rng_chan = 3'd0;
   logic [7:0]  rng_code = 8'd0;
   logic        res_ready = 1'b1;
   logic        miso = 1'b0;
   logic        res_valid, res_last, busy, rng_err, overrun, sclk, csn, mosi;
   logic [15:0] res_data;
   logic [2:0]  res_chan;

   adc_scan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .clk_div_i(clk_div), .scan_trig_i(scan_trig),
      .chan_mask_i(chan_mask), .rng_req_i(rng_req), .rng_chan_i(rng_chan),
      .rng_code_i(rng_code), .res_valid_o(res_valid), .res_ready_i(res_ready),
      .res_data_o(res_data), .res_chan_o(res_chan), .res_last_o(res_last),
      .busy_o(busy), .rng_err_o(rng_err), .overrun_o(overrun),
      .spi_sclk_o(sclk), .spi_csn_o(csn), .spi_mosi_o(mosi), .spi_miso_i(miso)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- converter model ----------------
   function automatic logic [15:0] adc_val(input int ch, input int s);
      return 16'(ch * 4369 + s * 257 + 3855);
   endfunction

   int          bitn = 0, sel_ch = 0, scan_id = 0, nfr = 0, rst_cmds = 0;
   logic [31:0] out_w = 0, in_w = 0;
   logic [31:0] fr_word [0:2047];
   int          fr_len  [0:2047];
   logic [7:0]  rng_reg [0:7];

   initial for (int i = 0; i < 8; i++) rng_reg[i] = 8'hFF;

   always @(negedge csn) begin
      bitn  = 0;
      in_w  = 0;
      out_w = {16'h0000, adc_val(sel_ch, scan_id)};
   end
   always @(posedge sclk) if (csn === 1'b0 && bitn < 32) miso = out_w[31 - bitn];
   always @(negedge sclk) if (csn === 1'b0) begin
      in_w = {in_w[30:0], mosi};
      bitn++;
   end
   always @(posedge csn) begin
      if (bitn > 0) begin
         if (nfr < 2048) begin
            fr_word[nfr] = in_w;
            fr_len[nfr]  = bitn;
         end
         nfr++;
         if (bitn == 32) begin
            if (in_w[31:29] == 3'b110 && in_w[25:24] == 2'b00) sel_ch = int'(in_w[28:26]);
            else if (in_w[31:24] == 8'h85) rst_cmds++;
         end else if (bitn == 24) begin
            if (in_w[23:17] >= 7'd5 && in_w[23:17] < 7'd13 && in_w[16])
               rng_reg[in_w[23:17] - 7'd5] = in_w[15:8];
         end
         bitn = 0;
      end
   end

   // timing measurement
   int gap_cnt = 0, gap_min = 1000000, hp_cnt = 0, hp_min = 1000000, hp_max = 0;
   bit hp_valid = 0;
   logic prev_sclk = 1'b0;
   always @(negedge csn) begin
      if (nfr > 0 && gap_cnt < gap_min) gap_min = gap_cnt;
      gap_cnt = 0;
   end
   always @(posedge clk) if (rst_n) begin
      if (csn === 1'b1) gap_cnt++;
      if (csn === 1'b0) begin
         if (sclk !== prev_sclk) begin
            if (hp_valid) begin
               if (hp_cnt < hp_min) hp_min = hp_cnt;
               if (hp_cnt > hp_max) hp_max = hp_cnt;
            end
            hp_valid = 1;
            hp_cnt = 1;
         end else hp_cnt++;
      end else hp_valid = 0;
      prev_sclk = sclk;
   end

   // result monitor
   logic [15:0] got_data [0:15];
   int          got_chan [0:15];
   bit          got_last [0:15];
   int          got_n = 0;
   always @(negedge clk) if (res_valid && res_ready) begin
      if (got_n < 16) begin
         got_data[got_n] = res_data;
         got_chan[got_n] = int'(res_chan);
         got_last[got_n] = res_last;
      end
      got_n++;
   end

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_scan(input logic [7:0] m, input int sid);
      int f0, k;
      scan_id = sid;
      got_n = 0;
      f0 = nfr;
      @(posedge clk); #1;
      chan_mask = m; scan_trig = 1'b1;
      @(posedge clk); #1;
      scan_trig = 1'b0;
      wait_idle();
      k = 0;
      for (int ch = 0; ch < 8; ch++) begin
         if (m[ch]) begin
            chk(got_chan[k] == ch, "R5", "channel order", got_chan[k], ch);
            chk(got_data[k] == adc_val(ch, sid), "R6", "result data", got_data[k], adc_val(ch, sid));
            chk(got_last[k] == ((m >> (ch + 1)) == 0), "R6", "last flag", got_last[k], (m >> (ch + 1)) == 0);
            chk(fr_word[f0 + 2*k] == {8'hC0 | 8'(ch << 2), 24'h0} && fr_len[f0 + 2*k] == 32,
                "R5", "select frame", fr_word[f0 + 2*k], {8'hC0 | 8'(ch << 2), 24'h0});
            chk(fr_word[f0 + 2*k + 1] == 32'h0 && fr_len[f0 + 2*k + 1] == 32,
                "R5", "no-op frame", fr_word[f0 + 2*k + 1], 0);
            k++;
         end
      end
      chk(got_n == k, "R7", "result count", got_n, k);
      chk(nfr - f0 == 2*k, "R7", "frame count", nfr - f0, 2*k);
   endtask

   task automatic rng_write(input int ch, input logic [7:0] code);
      int f0;
      bit ok;
      ok = (code == 0) || (code == 1) || (code == 2) || (code == 5) || (code == 6);
      f0 = nfr;
      @(posedge clk); #1;
      rng_chan = 3'(ch); rng_code = code; rng_req = 1'b1;
      @(posedge clk); #1;
      rng_req = 1'b0;
      @(negedge clk);
      if (ok) begin
         chk(rng_err == 1'b0, "R9", "no error on valid code", rng_err, 0);
         wait_idle();
         chk(nfr - f0 == 1 && fr_len[f0] == 24, "R9", "one 24-bit frame", fr_len[f0], 24);
         chk(fr_word[f0][23:0] == {7'(5 + ch), 1'b1, code, 8'h00}, "R9", "program frame",
             fr_word[f0][23:0], {7'(5 + ch), 1'b1, code, 8'h00});
         chk(rng_reg[ch] == code, "R9", "range register", rng_reg[ch], code);
      end else begin
         chk(rng_err == 1'b1, "R10", "error pulse", rng_err, 1);
         @(negedge clk);
         chk(rng_err == 1'b0, "R10", "pulse one cycle", rng_err, 0);
         repeat (4) @(negedge clk);
         chk(nfr == f0 && csn == 1'b1, "R10", "no frame sent", nfr - f0, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(csn == 1'b1 && sclk == 1'b0, "R1", "spi idle in reset", {csn, sclk}, 2'b10);
      chk(res_valid == 0 && rng_err == 0 && overrun == 0, "R1", "flags in reset",
          {res_valid, rng_err, overrun}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R1", "busy after reset", busy, 1);
      wait_idle();
      // R2 start-up command
      chk(nfr == 1 && rst_cmds == 1, "R2", "single reset frame", nfr, 1);
      chk(fr_word[0] == 32'h8500_0000 && fr_len[0] == 32, "R2", "reset frame content",
          fr_word[0], 32'h8500_0000);

      // R7 empty mask
      begin
         int f0;
         f0 = nfr;
         @(posedge clk); #1;
         chan_mask = 8'h00; scan_trig = 1'b1;
         @(posedge clk); #1;
         scan_trig = 1'b0;
         @(negedge clk);
         chk(busy == 1'b0, "R7", "empty mask not busy", busy, 0);
         repeat (10) @(negedge clk);
         chk(nfr == f0 && got_n == 0, "R7", "empty mask no frame", nfr - f0, 0);
      end

      // R5 R6 R7 mask sweep at fastest clock
      hp_min = 1000000; hp_max = 0; gap_min = 1000000;
      run_scan(8'hFF, 1);
      run_scan(8'h01, 2);
      run_scan(8'h80, 3);
      run_scan(8'hA5, 4);
      for (int i = 0; i < 60; i++) run_scan(8'((i * 37 + 11) & 255), 10 + i);
      // R3 R4 timing at divider 0
      chk(hp_min == 1 && hp_max == 1, "R3", "half period div0", hp_max, 1);
      chk(gap_min >= 1, "R4", "cs gap div0", gap_min, 1);

      // R3 R4 slower divider
      clk_div = 8'd3;
      hp_min = 1000000; hp_max = 0; gap_min = 1000000;
      run_scan(8'h81, 90);
      chk(hp_min == 4 && hp_max == 4, "R3", "half period div3", hp_min, 4);
      chk(gap_min >= 4, "R4", "cs gap div3", gap_min, 4);
      clk_div = 8'd0;

      // R9 R10 every range code
      for (int c = 0; c < 256; c++) rng_write(c % 8, 8'(c));

      // R8 back-pressure
      begin
         int f0;
         logic [15:0] held;
         res_ready = 1'b0;
         scan_id = 95; got_n = 0;
         @(posedge clk); #1;
         chan_mask = 8'h06; scan_trig = 1'b1;
         @(posedge clk); #1;
         scan_trig = 1'b0;
         while (!res_valid) @(negedge clk);
         held = res_data;
         f0 = nfr;
         repeat (50) @(negedge clk);
         chk(res_valid == 1'b1 && res_data == held, "R8", "result held", res_data, held);
         chk(res_chan == 3'd1, "R8", "held channel", res_chan, 1);
         chk(nfr == f0, "R8", "no frame while stalled", nfr - f0, 0);
         @(posedge clk); #1;
         res_ready = 1'b1;
         wait_idle();
         chk(got_n == 2 && got_chan[1] == 2 && got_data[1] == adc_val(2, 95), "R8",
             "stream resumes", got_data[1], adc_val(2, 95));
      end

      // R11 overrun
      begin
         int f0;
         chk(overrun == 1'b0, "R11", "overrun clear before", overrun, 0);
         scan_id = 97; got_n = 0; f0 = nfr;
         @(posedge clk); #1;
         chan_mask = 8'h01; scan_trig = 1'b1;
         @(posedge clk); #1;
         scan_trig = 1'b0;
         repeat (10) @(posedge clk);
         #1;
         chan_mask = 8'hFF; scan_trig = 1'b1;
         @(posedge clk); #1;
         scan_trig = 1'b0;
         chan_mask = 8'h00;
         wait_idle();
         chk(overrun == 1'b1, "R11", "overrun set", overrun, 1);
         chk(got_n == 1 && nfr - f0 == 2, "R11", "trigger dropped", nfr - f0, 2);
         repeat (20) @(negedge clk);
         chk(overrun == 1'b1 && nfr - f0 == 2, "R11", "overrun sticky", overrun, 1);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R7 watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule